// File: doc/BRIEF.md
# AES-128 Round Sequencing Controller

This block is the control half of a multi-cycle AES-128 engine that handles both encryption and decryption. It does not compute anything itself. Each cycle it tells an external datapath which registered transformation stage to capture: byte substitution, row shifting, column mixing, their inverses, the round-key addition, or the final output. The datapath owns the round counter. It sends back three comparison flags, and the controller uses them to decide how many rounds remain. The controller drives the counter with one-cycle up and down strobes.

A user raises `start` with `decrypt` set to select the direction. The controller then pulses `load` so the datapath captures key and text. It next walks one stage per cycle through the round schedule and captures the result with `en_dout`. After that it holds `done` high until the user lowers `start`. Both directions take the same 42 cycles from the `load` cycle to the first `done` cycle. Three phase indicators tell the datapath's key selection which round it is in.

Top module: `aes_round_seq_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it drops with `start` low, every output is 0 and the controller is idle.
- R2: `start` seen high while idle latches `decrypt` and gives a single-cycle `load` pulse in the next cycle. The stage after `load` is an initial key addition (`en_rnd`) together with one counter strobe: `cnt_up` when encrypting (`decrypt`=0), `cnt_down` when decrypting (`decrypt`=1).
- R3: When encrypting, the initial key addition cycle also raises `ph_first`.
- R4: An encryption round runs `en_sub`, `en_shift`, `en_mix`, then `en_rnd` with `cnt_up`, one per cycle. At that key addition, `cnt_lt_nine` high starts another full round.
- R5: At an encryption key addition with `cnt_lt_nine` low and `cnt_lt_ten` high, the final round runs `en_sub`, `en_shift`, then `en_rnd` with `en_dout`. No mix stage runs, and `ph_last` is high in all three cycles. With both flags low the controller goes straight to done.
- R6: When decrypting, the initial key addition raises `ph_last`. Each inverse round runs `en_ishift`, `en_isub`, then `en_rnd` with `cnt_down`, then `en_imix`. In the `en_imix` cycle, `cnt_gt_zero` high starts another inverse round. Otherwise the final inverse round runs `en_ishift`, `en_isub`, then `en_rnd` with `en_dout`, with no inverse mix and with `ph_first` high in all three cycles.
- R7: `ph_penult` is high in a round-body stage (not the initial or final round) exactly when `cnt_lt_ten` is high and `cnt_lt_nine` is low, that is, when the counter holds 9.
- R8: `done` rises in the cycle after `en_dout` and stays high while `start` is high. It falls, with the controller idle, in the cycle after `start` is seen low. A change of `start` or `decrypt` during an operation does not alter its schedule.
- R9: At most one of the six transformation enables is high in any cycle. `cnt_up` and `cnt_down` are never high together. `load`, `en_rnd` and `en_dout` never stay high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; also held to keep `done` |
| decrypt | input | 1 | 1 selects decryption, 0 encryption; sampled with `start` |
| cnt_lt_nine | input | 1 | Datapath round counter below 9 |
| cnt_lt_ten | input | 1 | Datapath round counter below 10 |
| cnt_gt_zero | input | 1 | Datapath round counter above 0 |
| load | output | 1 | Capture key and text into the datapath |
| cnt_up | output | 1 | Increment round counter |
| cnt_down | output | 1 | Decrement round counter |
| ph_first | output | 1 | Round using key 0 is active |
| ph_penult | output | 1 | Round-body stage while counter is 9 |
| ph_last | output | 1 | Round using key 10 is active |
| en_sub | output | 1 | Capture substitute-bytes stage |
| en_shift | output | 1 | Capture shift-rows stage |
| en_mix | output | 1 | Capture mix-columns stage |
| en_isub | output | 1 | Capture inverse substitute stage |
| en_ishift | output | 1 | Capture inverse shift-rows stage |
| en_imix | output | 1 | Capture inverse mix-columns stage |
| en_rnd | output | 1 | Capture key-addition result into the round register |
| en_dout | output | 1 | Capture the result into the output register |
| done | output | 1 | Operation finished |

## Verification
The assertions watch, on every cycle, the local rules of the schedule. These are the one-hot stage enables, the exclusive counter strobes, the single-cycle pulses, the order of adjacent stages within a round, the `done` hold and release handshake, and the count-of-nine condition for `ph_penult`. Some properties concern the whole operation, and only the bench scenarios show them. A behavioural counter stub closes the loop with the flags, and the bench compares the complete cycle-by-cycle strobe pattern against its own schedule. It shows that encryption runs exactly nine full rounds and one round without mixing. It shows that decryption counts the datapath counter from 10 down to 0. It also shows that a reset or a mode change mid-operation leaves no trace.

// File: rtl/aes_seq_pkg.sv
package aes_seq_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_LOAD,
    E_ARK0,
    E_SUB,
    E_SHIFT,
    E_MIX,
    E_ARK,
    E_FSUB,
    E_FSHIFT,
    E_FARK,
    D_ARK0,
    D_ISHIFT,
    D_ISUB,
    D_ARK,
    D_IMIX,
    D_FISHIFT,
    D_FISUB,
    D_FARK,
    ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic load;
    logic up;
    logic down;
    logic first;
    logic penult;
    logic last;
    logic sub;
    logic shift;
    logic mix;
    logic isub;
    logic ishift;
    logic imix;
    logic rnd;
    logic dout;
    logic done;
  } seq_strobe_t;

  // Counter equals 9 when it is below ten but not below nine.
  function automatic logic count_is_nine(input logic lt_nine, input logic lt_ten);
    return lt_ten & ~lt_nine;
  endfunction

  function automatic logic is_enc_body(input seq_state_t s);
    return (s == E_SUB) || (s == E_SHIFT) || (s == E_MIX) || (s == E_ARK);
  endfunction

  function automatic logic is_dec_body(input seq_state_t s);
    return (s == D_ISHIFT) || (s == D_ISUB) || (s == D_ARK) || (s == D_IMIX);
  endfunction

  function automatic logic is_enc_final(input seq_state_t s);
    return (s == E_FSUB) || (s == E_FSHIFT) || (s == E_FARK);
  endfunction

  function automatic logic is_dec_final(input seq_state_t s);
    return (s == D_FISHIFT) || (s == D_FISUB) || (s == D_FARK);
  endfunction

endpackage

// File: rtl/aes_seq_state.sv
module aes_seq_state
  import aes_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t nxt,
  input  logic       take,
  input  logic       dec_in,
  output seq_state_t state,
  output logic       dec_mode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      dec_mode <= 1'b0;
    end else begin
      state <= nxt;
      if (take) begin
        dec_mode <= dec_in;
      end
    end
  end

endmodule

// File: rtl/aes_seq_next.sv
module aes_seq_next
  import aes_seq_pkg::*;
(
  input  seq_state_t state,
  input  logic       start,
  input  logic       dec_mode,
  input  logic       lt_nine,
  input  logic       lt_ten,
  input  logic       gt_zero,
  output seq_state_t nxt
);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start) nxt = ST_LOAD;
      ST_LOAD:   nxt = dec_mode ? D_ARK0 : E_ARK0;
      // encryption
      E_ARK0:    nxt = E_SUB;
      E_SUB:     nxt = E_SHIFT;
      E_SHIFT:   nxt = E_MIX;
      E_MIX:     nxt = E_ARK;
      E_ARK: begin
        if (lt_nine)     nxt = E_SUB;
        else if (lt_ten) nxt = E_FSUB;
        else             nxt = ST_DONE;
      end
      E_FSUB:    nxt = E_FSHIFT;
      E_FSHIFT:  nxt = E_FARK;
      E_FARK:    nxt = ST_DONE;
      // decryption
      D_ARK0:    nxt = D_ISHIFT;
      D_ISHIFT:  nxt = D_ISUB;
      D_ISUB:    nxt = D_ARK;
      D_ARK:     nxt = D_IMIX;
      D_IMIX:    nxt = gt_zero ? D_ISHIFT : D_FISHIFT;
      D_FISHIFT: nxt = D_FISUB;
      D_FISUB:   nxt = D_FARK;
      D_FARK:    nxt = ST_DONE;
      ST_DONE:   if (!start) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/aes_seq_decode.sv
module aes_seq_decode
  import aes_seq_pkg::*;
(
  input  seq_state_t  state,
  input  logic        lt_nine,
  input  logic        lt_ten,
  output seq_strobe_t stb
);

  logic nine;
  assign nine = count_is_nine(lt_nine, lt_ten);

  always_comb begin
    stb        = '0;
    stb.penult = (is_enc_body(state) || is_dec_body(state)) && nine;
    stb.first  = (state == E_ARK0) || is_dec_final(state);
    stb.last   = (state == D_ARK0) || is_enc_final(state);
    unique case (state)
      ST_LOAD:   stb.load = 1'b1;
      E_ARK0:    begin stb.rnd = 1'b1; stb.up = 1'b1; end
      E_SUB:     stb.sub = 1'b1;
      E_SHIFT:   stb.shift = 1'b1;
      E_MIX:     stb.mix = 1'b1;
      E_ARK:     begin stb.rnd = 1'b1; stb.up = 1'b1; end
      E_FSUB:    stb.sub = 1'b1;
      E_FSHIFT:  stb.shift = 1'b1;
      E_FARK:    begin stb.rnd = 1'b1; stb.dout = 1'b1; end
      D_ARK0:    begin stb.rnd = 1'b1; stb.down = 1'b1; end
      D_ISHIFT:  stb.ishift = 1'b1;
      D_ISUB:    stb.isub = 1'b1;
      D_ARK:     begin stb.rnd = 1'b1; stb.down = 1'b1; end
      D_IMIX:    stb.imix = 1'b1;
      D_FISHIFT: stb.ishift = 1'b1;
      D_FISUB:   stb.isub = 1'b1;
      D_FARK:    begin stb.rnd = 1'b1; stb.dout = 1'b1; end
      ST_DONE:   stb.done = 1'b1;
      default:   ;
    endcase
  end

endmodule

// File: rtl/aes_round_seq_ctrl.sv
module aes_round_seq_ctrl
  import aes_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic decrypt,
  input  logic cnt_lt_nine,
  input  logic cnt_lt_ten,
  input  logic cnt_gt_zero,
  output logic load,
  output logic cnt_up,
  output logic cnt_down,
  output logic ph_first,
  output logic ph_penult,
  output logic ph_last,
  output logic en_sub,
  output logic en_shift,
  output logic en_mix,
  output logic en_isub,
  output logic en_ishift,
  output logic en_imix,
  output logic en_rnd,
  output logic en_dout,
  output logic done
);

  seq_state_t  state;
  seq_state_t  nxt;
  logic        dec_mode;
  seq_strobe_t stb;

  // named events for the checker
  logic start_take;
  logic release_evt;
  assign start_take  = (state == ST_IDLE) && start;
  assign release_evt = (state == ST_DONE) && !start;

  aes_seq_state u_state (
    .clk      (clk),
    .rst      (rst),
    .nxt      (nxt),
    .take     (start_take),
    .dec_in   (decrypt),
    .state    (state),
    .dec_mode (dec_mode)
  );

  aes_seq_next u_next (
    .state    (state),
    .start    (start),
    .dec_mode (dec_mode),
    .lt_nine  (cnt_lt_nine),
    .lt_ten   (cnt_lt_ten),
    .gt_zero  (cnt_gt_zero),
    .nxt      (nxt)
  );

  aes_seq_decode u_dec (
    .state   (state),
    .lt_nine (cnt_lt_nine),
    .lt_ten  (cnt_lt_ten),
    .stb     (stb)
  );

  assign load      = stb.load;
  assign cnt_up    = stb.up;
  assign cnt_down  = stb.down;
  assign ph_first  = stb.first;
  assign ph_penult = stb.penult;
  assign ph_last   = stb.last;
  assign en_sub    = stb.sub;
  assign en_shift  = stb.shift;
  assign en_mix    = stb.mix;
  assign en_isub   = stb.isub;
  assign en_ishift = stb.ishift;
  assign en_imix   = stb.imix;
  assign en_rnd    = stb.rnd;
  assign en_dout   = stb.dout;
  assign done      = stb.done;

endmodule

// File: rtl/aes_seq_chk.sv
module aes_seq_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic start_take,
  input logic release_evt,
  input logic cnt_lt_nine,
  input logic cnt_lt_ten,
  input logic cnt_gt_zero,
  input logic load,
  input logic cnt_up,
  input logic cnt_down,
  input logic ph_penult,
  input logic en_sub,
  input logic en_shift,
  input logic en_mix,
  input logic en_isub,
  input logic en_ishift,
  input logic en_imix,
  input logic en_rnd,
  input logic en_dout,
  input logic done
);

  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (rst)
    $countones({en_sub, en_shift, en_mix, en_isub, en_ishift, en_imix}) <= 1); // R9
  AST_UPDOWN_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cnt_up && cnt_down)); // R9
  AST_RND_PULSE: assert property (@(posedge clk) disable iff (rst)
    en_rnd |=> !en_rnd); // R9
  AST_DOUT_PULSE: assert property (@(posedge clk) disable iff (rst)
    en_dout |=> !en_dout); // R9
  AST_LOAD_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
    start_take |=> (load && !$past(load))); // R2
  AST_ARK0_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (en_rnd && (cnt_up || cnt_down) && !load)); // R2
  AST_SHIFT_AFTER_SUB: assert property (@(posedge clk) disable iff (rst)
    en_shift |-> $past(en_sub)); // R4
  AST_MIX_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst)
    en_mix |-> $past(en_shift)); // R4
  AST_ISUB_AFTER_ISHIFT: assert property (@(posedge clk) disable iff (rst)
    en_isub |-> $past(en_ishift)); // R6
  AST_IMIX_AFTER_ARK: assert property (@(posedge clk) disable iff (rst)
    en_imix |-> $past(en_rnd && cnt_down)); // R6
  AST_IMIX_LOOP: assert property (@(posedge clk) disable iff (rst)
    (en_imix && cnt_gt_zero) |=> en_ishift); // R6
  AST_FINAL_NO_MIX: assert property (@(posedge clk) disable iff (rst)
    en_dout |-> ($past(en_shift) || $past(en_isub))); // R5
  AST_DONE_AFTER_DOUT: assert property (@(posedge clk) disable iff (rst)
    en_dout |=> done); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> done); // R8
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    release_evt |=> (!done && !load)); // R8
  AST_PENULT_NINE: assert property (@(posedge clk) disable iff (rst)
    ph_penult |-> (cnt_lt_ten && !cnt_lt_nine)); // R7

endmodule

bind aes_round_seq_ctrl aes_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .start_take  (start_take),
  .release_evt (release_evt),
  .cnt_lt_nine (cnt_lt_nine),
  .cnt_lt_ten  (cnt_lt_ten),
  .cnt_gt_zero (cnt_gt_zero),
  .load        (load),
  .cnt_up      (cnt_up),
  .cnt_down    (cnt_down),
  .ph_penult   (ph_penult),
  .en_sub      (en_sub),
  .en_shift    (en_shift),
  .en_mix      (en_mix),
  .en_isub     (en_isub),
  .en_ishift   (en_ishift),
  .en_imix     (en_imix),
  .en_rnd      (en_rnd),
  .en_dout     (en_dout),
  .done        (done)
);

// File: tb/sim_aes_round_seq_ctrl.sv
module sim_aes_round_seq_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic decrypt = 1'b0;
  logic cnt_lt_nine, cnt_lt_ten, cnt_gt_zero;
  logic load, cnt_up, cnt_down, ph_first, ph_penult, ph_last;
  logic en_sub, en_shift, en_mix, en_isub, en_ishift, en_imix;
  logic en_rnd, en_dout, done;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  aes_round_seq_ctrl u0 (
    .clk(clk), .rst(rst), .start(start), .decrypt(decrypt),
    .cnt_lt_nine(cnt_lt_nine), .cnt_lt_ten(cnt_lt_ten), .cnt_gt_zero(cnt_gt_zero),
    .load(load), .cnt_up(cnt_up), .cnt_down(cnt_down),
    .ph_first(ph_first), .ph_penult(ph_penult), .ph_last(ph_last),
    .en_sub(en_sub), .en_shift(en_shift), .en_mix(en_mix),
    .en_isub(en_isub), .en_ishift(en_ishift), .en_imix(en_imix),
    .en_rnd(en_rnd), .en_dout(en_dout), .done(done)
  );

  // behavioural datapath counter stub
  logic       op_mode = 1'b0;
  logic [4:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)           cnt <= 5'd0;
    else if (load)     cnt <= op_mode ? 5'd10 : 5'd0;
    else if (cnt_up)   cnt <= cnt + 5'd1;
    else if (cnt_down) cnt <= cnt - 5'd1;
  end
  assign cnt_lt_nine = (cnt < 5'd9);
  assign cnt_lt_ten  = (cnt < 5'd10);
  assign cnt_gt_zero = (cnt > 5'd0);

  function automatic logic [14:0] outs();
    return {load, cnt_up, cnt_down, ph_first, ph_penult, ph_last,
            en_sub, en_shift, en_mix, en_isub, en_ishift, en_imix,
            en_rnd, en_dout, done};
  endfunction

  // bit map: load14 up13 down12 first11 penult10 last9 sub8 shift7 mix6
  //          isub5 ishift4 imix3 rnd2 dout1 done0 ; i = cycles after load
  function automatic logic [14:0] exp_vec(logic m, int i);
    logic [14:0] v;
    v = '0;
    if (i == 0) v[14] = 1'b1;
    else if (i == 1) begin
      v[2] = 1'b1;
      if (!m) begin v[11] = 1'b1; v[13] = 1'b1; end
      else    begin v[9]  = 1'b1; v[12] = 1'b1; end
    end else if (i <= 37) begin
      int k;
      k = (i - 2) % 4;
      if (!m) begin
        case (k)
          0: v[8] = 1'b1;
          1: v[7] = 1'b1;
          2: v[6] = 1'b1;
          default: begin v[2] = 1'b1; v[13] = 1'b1; end
        endcase
        if (i >= 34) v[10] = 1'b1;
      end else begin
        case (k)
          0: v[4] = 1'b1;
          1: v[5] = 1'b1;
          2: begin v[2] = 1'b1; v[12] = 1'b1; end
          default: v[3] = 1'b1;
        endcase
        if (i <= 4) v[10] = 1'b1;
      end
    end else if (i <= 40) begin
      if (!m) begin
        v[9] = 1'b1;
        case (i)
          38: v[8] = 1'b1;
          39: v[7] = 1'b1;
          default: begin v[2] = 1'b1; v[1] = 1'b1; end
        endcase
      end else begin
        v[11] = 1'b1;
        case (i)
          38: v[4] = 1'b1;
          39: v[5] = 1'b1;
          default: begin v[2] = 1'b1; v[1] = 1'b1; end
        endcase
      end
    end else v[0] = 1'b1;
    return v;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // vector: mode(1) hold(4) exp_cnt(4) exp_up(4) exp_down(4) flip(1)
  localparam int NV = 5;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 4'd2, 4'd10, 4'd10, 4'd0,  1'b0},
    {1'b1, 4'd3, 4'd0,  4'd0,  4'd10, 1'b0},
    {1'b0, 4'd0, 4'd10, 4'd10, 4'd0,  1'b1},
    {1'b1, 4'd5, 4'd0,  4'd0,  4'd10, 1'b1},
    {1'b0, 4'd1, 4'd10, 4'd10, 4'd0,  1'b0}
  };

  task automatic run_op(input logic [17:0] v);
    logic m, flip;
    int hold, mism, ups, downs, bad_i;
    logic [14:0] bad_got, bad_exp;
    m = v[17]; hold = int'(v[16:13]); flip = v[0];
    mism = 0; ups = 0; downs = 0; bad_i = -1; bad_got = '0; bad_exp = '0;
    @(negedge clk);
    decrypt = m; op_mode = m; start = 1'b1;
    for (int i = 0; i < 42; i++) begin
      @(negedge clk);
      if (outs() != exp_vec(m, i)) begin
        if (mism == 0) begin bad_i = i; bad_got = outs(); bad_exp = exp_vec(m, i); end
        mism++;
      end
      ups += int'(cnt_up);
      downs += int'(cnt_down);
      if (flip && i == 5) begin decrypt = ~m; start = 1'b0; end
      if (flip && i == 9) start = 1'b1;
    end
    // R2 R3 R4 R5 R6 R7 full schedule
    check(mism == 0, m ? "R6 R7 decrypt schedule" : "R3 R4 R5 R7 encrypt schedule",
          int'(bad_got), int'(bad_exp));
    if (mism != 0) $display("  first mismatch at cycle %0d", bad_i);
    check(cnt == 5'(v[12:9]), "R4 R6 final counter", int'(cnt), int'(v[12:9]));
    check(ups == int'(v[8:5]), "R4 up strobes", ups, int'(v[8:5]));
    check(downs == int'(v[4:1]), "R6 down strobes", downs, int'(v[4:1]));
    begin
      int held;
      held = 0;
      for (int j = 0; j < hold; j++) begin
        @(negedge clk);
        if (outs() == 15'h0001) held++;
      end
      check(held == hold, "R8 done held while start high", held, hold);
    end
    start = 1'b0;
    @(negedge clk); // done state sees start low here
    @(negedge clk);
    check(outs() == 15'h0, "R8 idle after release", int'(outs()), 0);
    decrypt = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(outs() == 15'h0, "R1 outputs during reset", int'(outs()), 0);
    rst = 1'b0;
    @(negedge clk);
    check(outs() == 15'h0, "R1 idle after reset", int'(outs()), 0);

    for (int n = 0; n < NV; n++) run_op(VEC[n]);

    // R2 idle without start never loads
    begin
      int seen;
      seen = 0;
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        if (outs() != 15'h0) seen++;
      end
      check(seen == 0, "R2 no activity without start", seen, 0);
    end

    // R1 reset mid-operation
    @(negedge clk);
    decrypt = 1'b1; op_mode = 1'b1; start = 1'b1;
    repeat (12) @(negedge clk);
    rst = 1'b1; start = 1'b0;
    @(negedge clk);
    check(outs() == 15'h0, "R1 reset mid-operation", int'(outs()), 0);
    rst = 1'b0;
    @(negedge clk);
    check(outs() == 15'h0, "R1 idle after mid-op reset", int'(outs()), 0);

    // R2 start samples mode; first cycle after start is load
    @(negedge clk);
    decrypt = 1'b0; op_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    check(load == 1'b1, "R2 load pulse", int'(load), 1);
    @(negedge clk);
    check(outs() == exp_vec(1'b0, 1), "R2 encrypt initial key step", int'(outs()),
          int'(exp_vec(1'b0, 1)));
    repeat (45) @(negedge clk);
    check(done == 1'b1, "R8 done reached", int'(done), 1);
    start = 1'b0;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R8 done cleared", int'(done), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule